// File: doc/BRIEF.md
# ASID-Selective TLB Flush Scanner

This block removes, on request, every cached translation that belongs to one address-space identifier. A single start command carries the identifier. The engine then walks every entry of both translation caches, the instruction side and the data side, across all ways and rows. It reads each entry through a synchronous read port into storage that lives outside the block.

For each entry that is valid, not global and tagged with the requested identifier, the engine emits a one-cycle flush strobe. The strobe carries the page's virtual address. Entries that do not qualify produce nothing and cost no extra cycles. When the last entry has been examined, a done pulse marks the end of the walk. Global translations are never selected, whatever their identifier.

Top module: `tlb_asid_sweep`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `flush_vld_o` and `rd_en_o` are all low.
- R2: A sweep issues exactly 128 reads, one per cycle, with no gaps. The read index is the concatenation {side, way, row}, with the row varying fastest, then the way, then the side. It starts at index 0.
- R3: An entry is flushed only when all of the following hold: low word bit 3 (valid) is 1, low word bit 4 (global) is 0, and high word bits 7:0 equal the latched identifier.
- R4: Only bits 7:0 of `asid_i` take part in the comparison. The upper bits have no effect.
- R5: The flush address equals high word bits 31:13, with bits 12:0 forced to zero.
- R6: Each qualifying entry raises `flush_vld_o` in the cycle after its read is issued. Flushes come out in read order. A non-qualifying entry produces no strobe and does not delay later entries.
- R7: `done_o` is high for exactly one cycle, one cycle after the last entry's data cycle. That is 130 cycles after the clock edge that accepts `start_i`. `busy_o` falls in the same cycle.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The sweep in progress keeps its identifier, and no extra sweep or done pulse follows.
- R9: An entry with the global bit set is never flushed, even when its identifier matches and it is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sweep request, sampled when idle |
| asid_i | input | 32 | Identifier to flush; only bits 7:0 are used |
| rd_en_o | output | 1 | Read request to entry storage |
| rd_side_o | output | 1 | Side select: 0 instruction, 1 data |
| rd_way_o | output | 2 | Way select |
| rd_row_o | output | 4 | Row select |
| rd_lo_i | input | 32 | Low word of the entry, one cycle after rd_en_o |
| rd_hi_i | input | 32 | High word of the entry, one cycle after rd_en_o |
| flush_vld_o | output | 1 | Flush strobe |
| flush_addr_o | output | 32 | Virtual page address to flush |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bound checker watches every cycle for several properties. It checks that reads advance by exactly one index with the row fastest. It checks that a strobe appears only one cycle after a read, and only with a valid, non-global entry and a page-aligned address. It also checks that `done_o` is a single-cycle pulse that ends `busy_o`, and that the latched identifier holds steady while a sweep runs.

Some behaviour only the bench scenarios can show. These are that exactly the right set of entries is flushed, in order, for all-match, mixed, no-match and random tables. They also include the upper identifier bits being ignored, the 130-cycle latency, and a mid-sweep start leaving no trace.

// File: rtl/tlb_asid_sweep.sv
module tlb_asid_sweep #(
  parameter int SIDES      = 2,
  parameter int WAYS       = 4,
  parameter int ROWS       = 16,
  parameter int ID_W       = 8,
  parameter int ASID_IN_W  = 32,
  parameter int PAGE_LSB   = 13,
  parameter int VALID_BIT  = 3,
  parameter int GLOBAL_BIT = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [ASID_IN_W-1:0]              asid_i,
  output logic                              rd_en_o,
  output logic [((SIDES>1)?$clog2(SIDES):1)-1:0] rd_side_o,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]   rd_way_o,
  output logic [((ROWS>1)?$clog2(ROWS):1)-1:0]   rd_row_o,
  input  logic [31:0]                       rd_lo_i,
  input  logic [31:0]                       rd_hi_i,
  output logic                              flush_vld_o,
  output logic [31:0]                       flush_addr_o,
  output logic                              busy_o,
  output logic                              done_o
);
  localparam int S_W     = (SIDES > 1) ? $clog2(SIDES) : 1;
  localparam int W_W     = (WAYS  > 1) ? $clog2(WAYS)  : 1;
  localparam int R_W     = (ROWS  > 1) ? $clog2(ROWS)  : 1;
  localparam int IDX_W   = S_W + W_W + R_W;
  localparam int ENTRIES = SIDES * WAYS * ROWS;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             act, pend, pend_last, busy_q, done_q;
  logic [IDX_W-1:0] cnt;
  logic [ID_W-1:0]  id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act       <= 1'b0;
      pend      <= 1'b0;
      pend_last <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cnt       <= '0;
      id_q      <= '0;
    end else begin
      done_q    <= pend_last;
      pend      <= act;
      pend_last <= act && (cnt == LAST);
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        act    <= 1'b1;
        cnt    <= '0;
        id_q   <= asid_i[ID_W-1:0];
      end else begin
        if (act) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) act <= 1'b0;
        end
        if (pend_last) busy_q <= 1'b0;
      end
    end
  end

  assign rd_en_o   = act;
  assign rd_row_o  = cnt[R_W-1:0];
  assign rd_way_o  = cnt[R_W +: W_W];
  assign rd_side_o = cnt[R_W+W_W +: S_W];

  assign flush_vld_o  = pend && rd_lo_i[VALID_BIT] && !rd_lo_i[GLOBAL_BIT]
                        && (rd_hi_i[ID_W-1:0] == id_q);
  assign flush_addr_o = {rd_hi_i[31:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign busy_o       = busy_q;
  assign done_o       = done_q;
endmodule

// File: rtl/tlb_asid_sweep_chk.sv
module tlb_asid_sweep_chk #(
  parameter int S_W        = 1,
  parameter int W_W        = 2,
  parameter int R_W        = 4,
  parameter int ID_W       = 8,
  parameter int PAGE_LSB   = 13,
  parameter int VALID_BIT  = 3,
  parameter int GLOBAL_BIT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en_o,
  input logic [S_W-1:0]  rd_side_o,
  input logic [W_W-1:0]  rd_way_o,
  input logic [R_W-1:0]  rd_row_o,
  input logic [31:0]     rd_lo_i,
  input logic            flush_vld_o,
  input logic [31:0]     flush_addr_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [ID_W-1:0] id_q
);
  localparam int IX_W = S_W + W_W + R_W;
  logic [IX_W-1:0] idx;
  assign idx = {rd_side_o, rd_way_o, rd_row_o};

  // R2
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_o) |-> idx == '0);
  // R2
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o && $past(rd_en_o) |-> idx == IX_W'($past(idx) + 1'b1));
  // R6
  flush_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld_o |-> $past(rd_en_o));
  // R3
  flush_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld_o |-> rd_lo_i[VALID_BIT]);
  // R9
  global_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld_o |-> !rd_lo_i[GLOBAL_BIT]);
  // R5
  page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld_o |-> flush_addr_o[PAGE_LSB-1:0] == '0);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o && $past(busy_o));
  // R8
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(id_q));
endmodule

bind tlb_asid_sweep tlb_asid_sweep_chk #(
  .S_W(S_W), .W_W(W_W), .R_W(R_W), .ID_W(ID_W), .PAGE_LSB(PAGE_LSB),
  .VALID_BIT(VALID_BIT), .GLOBAL_BIT(GLOBAL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_o(rd_en_o), .rd_side_o(rd_side_o),
  .rd_way_o(rd_way_o), .rd_row_o(rd_row_o), .rd_lo_i(rd_lo_i),
  .flush_vld_o(flush_vld_o), .flush_addr_o(flush_addr_o),
  .busy_o(busy_o), .done_o(done_o), .id_q(id_q)
);

// File: tb/test_tlb_asid_sweep.sv
module test_tlb_asid_sweep;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] asid_i = '0;
  logic        rd_en_o, flush_vld_o, busy_o, done_o;
  logic [0:0]  rd_side_o;
  logic [1:0]  rd_way_o;
  logic [3:0]  rd_row_o;
  logic [31:0] rd_lo_i, rd_hi_i, flush_addr_o;

  int errors = 0, checks = 0;
  int cyc = 0, rd_exp = 0, done_cnt = 0, done_cyc = 0, flush_cnt = 0;
  bit finished = 0;
  logic [31:0] lo_m [128];
  logic [31:0] hi_m [128];
  logic [31:0] exp_q [$];

  always #5 clk = ~clk;

  tlb_asid_sweep i_tlb_asid_sweep (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .asid_i(asid_i),
    .rd_en_o(rd_en_o), .rd_side_o(rd_side_o), .rd_way_o(rd_way_o),
    .rd_row_o(rd_row_o), .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i),
    .flush_vld_o(flush_vld_o), .flush_addr_o(flush_addr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always_ff @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en_o) begin
      rd_lo_i <= lo_m[{rd_side_o, rd_way_o, rd_row_o}];
      rd_hi_i <= hi_m[{rd_side_o, rd_way_o, rd_row_o}];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en_o) begin
        chk({25'd0, rd_side_o, rd_way_o, rd_row_o} == rd_exp, "R2 read order",
            {25'd0, rd_side_o, rd_way_o, rd_row_o}, rd_exp);
        rd_exp++;
      end
      if (flush_vld_o) begin
        flush_cnt++;
        if (exp_q.size() == 0) chk(0, "R3 unexpected flush", flush_addr_o, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(flush_addr_o == e, "R5/R6 flush address", flush_addr_o, e);
        end
      end
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic fill(input int mode, input logic [7:0] id);
    for (int k = 0; k < 128; k++) begin
      logic [7:0] pid;
      logic [1:0] fl;
      pid = id;
      fl  = 2'b01;
      case (mode)
        1: case (k % 4)
             1: fl = 2'b11;
             2: fl = 2'b00;
             3: pid = id ^ 8'h01;
             default: ;
           endcase
        2: pid = id ^ 8'h80;
        3: begin fl = 2'($urandom); pid = ($urandom % 2) ? id : id ^ 8'h10; end
        default: ;
      endcase
      hi_m[k] = {19'((k * 37 + mode * 1000) & 19'h7ffff), 5'h0, pid};
      lo_m[k] = {19'(k * 11), 8'h0, fl, 3'b101};
    end
  endtask

  // driver: fills storage, pushes expectations computed from R3/R4/R5
  task automatic sweep(input int mode, input logic [31:0] asid, input string tag, input bit poke);
    int start_cyc, dc0, fc0, nexp;
    fill(mode, asid[7:0]);
    nexp = 0;
    for (int k = 0; k < 128; k++)
      if (lo_m[k][3] && !lo_m[k][4] && hi_m[k][7:0] == asid[7:0]) begin
        exp_q.push_back({hi_m[k][31:13], 13'd0});
        nexp++;
      end
    dc0 = done_cnt; fc0 = flush_cnt; rd_exp = 0;
    @(negedge clk);
    start_i = 1'b1; asid_i = asid; start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, {tag, " R2 busy after start"}, busy_o, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start_i = 1'b1; asid_i = asid ^ 32'h0000_00ff;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == dc0 && cyc - start_cyc < 400) @(negedge clk);
    chk(done_cyc - start_cyc == 130, {tag, " R7 done latency"}, done_cyc - start_cyc, 130);
    chk(!busy_o, {tag, " R7 busy low at done"}, busy_o, 0);
    @(negedge clk);
    chk(!done_o, {tag, " R7 done one cycle"}, done_o, 0);
    chk(rd_exp == 128, {tag, " R2 read count"}, rd_exp, 128);
    chk(flush_cnt - fc0 == nexp, {tag, " R3/R6 flush count"}, flush_cnt - fc0, nexp);
    chk(exp_q.size() == 0, {tag, " R6 missing flush"}, exp_q.size(), 0);
    exp_q.delete();
    if (poke) begin
      repeat (30) @(negedge clk);
      chk(!busy_o && done_cnt == dc0 + 1, {tag, " R8 ignored start"}, done_cnt - dc0, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy_o && !done_o && !flush_vld_o && !rd_en_o, "R1 reset state",
        {busy_o, done_o, flush_vld_o, rd_en_o}, 0);
    rst_n = 1'b1;
    sweep(0, 32'h0000_0005, "all-match", 0);
    sweep(1, 32'h0000_0142, "mixed R4 R9", 0);
    sweep(2, 32'h0000_0033, "none", 0);
    sweep(1, 32'hABCD_0077, "busy-start", 1);
    sweep(3, 32'h0000_00C1, "random", 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule